// File: doc/BRIEF.md
# Transmit Frame Slot with Life-Cycle Controller

This block holds one outgoing frame of a CAN FD controller. A small two-port RAM keeps the frame words: software fills it through a write-only port, and the hardware readers (the protocol engine and the transmit arbiter) fetch words through a read-only port with one cycle of latency. A state machine follows the slot through its life cycle. It takes commands from software and from the protocol engine, tells the arbiter whether the slot may be picked, and reports its state and retry count back to software.

Software and the protocol engine run independently, so one command from each can land in the same cycle. Software wins such a collision: an abort that meets a lock in the same cycle leaves the slot aborted. An abort that arrives while a transmission is under way cannot stop the frame already on the wire. Instead the slot moves to an intermediate state in which exactly one attempt finishes, and it retries no more. A failed attempt after an error or lost arbitration sends the slot back to the pool and counts a retry. When the count has already reached a configurable limit, the slot stops retrying and reports failure.

Top module: `tx_frame_slot`

## Requirements
- R1: After reset the state code is 0 (Empty), the retry count is 0, `available_o` is 0 and `hw_rd_data_o` is 0.
- R2: State codes are Empty=0, Ready=1, Sending=2, AbortPending=3, Sent=4, Aborted=5, Failed=6. The software command code 1 (set-ready) in Empty, Sent, Aborted or Failed moves the slot to Ready on the next clock and clears the retry count.
- R3: A software command whose code is not valid in the current state leaves the state and retry count unchanged. Software codes are 0 none, 1 set-ready, 2 set-empty, 3 set-abort.
- R4: Set-empty (code 2) in Sent, Aborted or Failed moves the slot to Empty.
- R5: Hardware codes are 0 none, 1 lock, 2 unlock-ok, 3 unlock-error (error or lost arbitration), 4 unlock-fail. Lock moves Ready to Sending. Unlock-ok moves Sending to Sent, and unlock-fail moves Sending to Failed. Lock arrives only in Ready, and unlock codes arrive only in Sending or AbortPending.
- R6: Unlock-error in Sending, with the retry count below `retry_limit_i`, moves the slot to Ready and adds one to the retry count.
- R7: Unlock-error in Sending, with the retry count equal to `retry_limit_i`, moves the slot to Failed and leaves the count unchanged.
- R8: Set-abort moves Ready to Aborted and moves Sending to AbortPending.
- R9: In AbortPending, unlock-error leads to Aborted, unlock-ok to Sent and unlock-fail to Failed. No further lock is possible from any of these states.
- R10: Set-abort together with lock in Ready gives Aborted. Set-abort together with an unlock code in Sending gives the AbortPending outcome of that code.
- R11: `available_o` is 1 exactly while the state is Ready.
- R12: A software write in Empty, Sent, Aborted or Failed stores the word. `hw_rd_data_o` shows the word at `hw_rd_addr_i` one clock after the address is presented, and a read in the same cycle as a write to that address returns the old word.
- R13: A software write while the state is Ready, Sending or AbortPending does not change the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_cmd_i | input | 2 | Software command code |
| hw_cmd_i | input | 3 | Protocol engine command code |
| retry_limit_i | input | RETRY_W | Largest retry count that still allows a retry |
| sw_we_i | input | 1 | Software write strobe |
| sw_addr_i | input | AW | Software write word address |
| sw_wdata_i | input | DW | Software write data |
| hw_rd_addr_i | input | AW | Hardware read word address |
| hw_rd_data_o | output | DW | Hardware read data, one cycle latency |
| state_o | output | 3 | Current state code |
| retry_cnt_o | output | RETRY_W | Retries counted since the last set-ready |
| available_o | output | 1 | Slot may be picked by the arbiter |

## Verification
The bench builds the slot with 8 words of 16 bits and a 3-bit retry count. The small depth lets random reads fall on words that were written earlier in both unlocked and locked states. It also keeps the full retry range reachable in a few steps, so a limit of 2 in the random phase and a limit of 0 in a directed case reach both the retry path and the give-up path many times. Random command pairs are drawn only from those legal in the modelled state, which makes same-cycle software and hardware collisions frequent in Ready and Sending.

// File: rtl/txslot_pkg.sv
package txslot_pkg;

    typedef enum logic [2:0] {
        ST_EMPTY    = 3'd0,
        ST_READY    = 3'd1,
        ST_SENDING  = 3'd2,
        ST_ABTPEND  = 3'd3,
        ST_SENT     = 3'd4,
        ST_ABORTED  = 3'd5,
        ST_FAILED   = 3'd6
    } slot_st_e;

    typedef enum logic [1:0] {
        SW_NONE  = 2'd0,
        SW_READY = 2'd1,
        SW_EMPTY = 2'd2,
        SW_ABORT = 2'd3
    } sw_cmd_e;

    typedef enum logic [2:0] {
        HW_NONE = 3'd0,
        HW_LOCK = 3'd1,
        HW_OK   = 3'd2,
        HW_ERR  = 3'd3,
        HW_FAIL = 3'd4
    } hw_cmd_e;

    // Final states: frame finished, slot open to software again
    function automatic logic st_final(slot_st_e s);
        return (s == ST_SENT) || (s == ST_ABORTED) || (s == ST_FAILED);
    endfunction

    // States in which the frame RAM refuses software writes
    function automatic logic st_locked(slot_st_e s);
        return (s == ST_READY) || (s == ST_SENDING) || (s == ST_ABTPEND);
    endfunction

endpackage

// File: rtl/txslot_fsm.sv
module txslot_fsm
    import txslot_pkg::*;
#(
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sw_cmd_e            sw_cmd,
    input  hw_cmd_e            hw_cmd,
    input  logic [RETRY_W-1:0] retry_limit,
    output slot_st_e           state,
    output logic [RETRY_W-1:0] retry_cnt
);

    typedef struct packed {
        slot_st_e           st;
        logic [RETRY_W-1:0] retry;
    } fsm_t;

    fsm_t q, d;
    logic abort_req;

    always_comb begin
        d         = q;
        abort_req = (sw_cmd == SW_ABORT);
        case (q.st)
            ST_EMPTY: begin
                if (sw_cmd == SW_READY) begin
                    d.st    = ST_READY;
                    d.retry = '0;
                end
            end
            ST_READY: begin
                // software abort beats a simultaneous lock
                if (abort_req)               d.st = ST_ABORTED;
                else if (hw_cmd == HW_LOCK)  d.st = ST_SENDING;
            end
            ST_SENDING: begin
                case (hw_cmd)
                    HW_OK:   d.st = ST_SENT;
                    HW_FAIL: d.st = ST_FAILED;
                    HW_ERR: begin
                        if (abort_req) begin
                            d.st = ST_ABORTED;
                        end else if (q.retry == retry_limit) begin
                            d.st = ST_FAILED;
                        end else begin
                            d.st    = ST_READY;
                            d.retry = q.retry + 1'b1;
                        end
                    end
                    default: if (abort_req) d.st = ST_ABTPEND;
                endcase
            end
            ST_ABTPEND: begin
                case (hw_cmd)
                    HW_OK:   d.st = ST_SENT;
                    HW_FAIL: d.st = ST_FAILED;
                    HW_ERR:  d.st = ST_ABORTED;
                    default: d.st = ST_ABTPEND;
                endcase
            end
            ST_SENT, ST_ABORTED, ST_FAILED: begin
                if (sw_cmd == SW_READY) begin
                    d.st    = ST_READY;
                    d.retry = '0;
                end else if (sw_cmd == SW_EMPTY) begin
                    d.st = ST_EMPTY;
                end
            end
            default: d.st = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_EMPTY;
            q.retry <= '0;
        end else begin
            q <= d;
        end
    end

    assign state     = q.st;
    assign retry_cnt = q.retry;

endmodule

// File: rtl/txslot_ram.sv
module txslot_ram #(
    parameter int WORDS = 20,
    parameter int DW    = 32,
    localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_lock,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] rd_d, rd_q;
    logic          wr_ok;

    always_comb begin
        wr_ok = wr_en && !wr_lock && (int'(wr_addr) < WORDS);
        rd_d  = '0;
        if (int'(rd_addr) < WORDS) rd_d = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/tx_frame_slot.sv
module tx_frame_slot
    import txslot_pkg::*;
#(
    parameter int WORDS   = 20,
    parameter int DW      = 32,
    parameter int RETRY_W = 4,
    localparam int AW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         sw_cmd_i,
    input  logic [2:0]         hw_cmd_i,
    input  logic [RETRY_W-1:0] retry_limit_i,
    input  logic               sw_we_i,
    input  logic [AW-1:0]      sw_addr_i,
    input  logic [DW-1:0]      sw_wdata_i,
    input  logic [AW-1:0]      hw_rd_addr_i,
    output logic [DW-1:0]      hw_rd_data_o,
    output logic [2:0]         state_o,
    output logic [RETRY_W-1:0] retry_cnt_o,
    output logic               available_o
);

    slot_st_e st;
    hw_cmd_e  hw_cmd;

    always_comb begin
        case (hw_cmd_i)
            3'd1:    hw_cmd = HW_LOCK;
            3'd2:    hw_cmd = HW_OK;
            3'd3:    hw_cmd = HW_ERR;
            3'd4:    hw_cmd = HW_FAIL;
            default: hw_cmd = HW_NONE;
        endcase
    end

    txslot_fsm #(.RETRY_W(RETRY_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_cmd      (sw_cmd_e'(sw_cmd_i)),
        .hw_cmd      (hw_cmd),
        .retry_limit (retry_limit_i),
        .state       (st),
        .retry_cnt   (retry_cnt_o)
    );

    txslot_ram #(.WORDS(WORDS), .DW(DW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sw_we_i),
        .wr_lock (st_locked(st)),
        .wr_addr (sw_addr_i),
        .wr_data (sw_wdata_i),
        .rd_addr (hw_rd_addr_i),
        .rd_data (hw_rd_data_o)
    );

    assign state_o     = st;
    assign available_o = (st == ST_READY);

endmodule

// File: rtl/tx_frame_slot_chk.sv
module tx_frame_slot_chk #(
    parameter int RETRY_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         sw_cmd_i,
    input logic [2:0]         hw_cmd_i,
    input logic [RETRY_W-1:0] retry_limit_i,
    input logic [2:0]         state_o,
    input logic [RETRY_W-1:0] retry_cnt_o,
    input logic               available_o
);

    // R5: the protocol engine only locks a Ready slot
    p_lock_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_cmd_i == 3'd1) |-> (state_o == 3'd1));

    // R5: unlock codes only while a transmission is held
    p_unlock_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_cmd_i >= 3'd2 && hw_cmd_i <= 3'd4) |-> (state_o == 3'd2 || state_o == 3'd3));

    // R2: set-ready from a finished or empty slot
    p_set_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_cmd_i == 2'd1 && (state_o == 3'd0 || state_o >= 3'd4))
        |=> (state_o == 3'd1 && retry_cnt_o == '0));

    // R10: abort beats a lock in the same cycle
    p_abort_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && sw_cmd_i == 2'd3) |=> (state_o == 3'd5));

    // R6: a retry below the limit counts up and goes back to Ready
    p_retry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && hw_cmd_i == 3'd3 && sw_cmd_i != 2'd3 && retry_cnt_o != retry_limit_i)
        |=> (state_o == 3'd1 && retry_cnt_o == $past(retry_cnt_o) + 1'b1));

    // R9: a pending abort ends after a single attempt
    p_single_attempt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && hw_cmd_i == 3'd3) |=> (state_o == 3'd5));

    // R11: the arbiter flag rises only on entry into Ready
    p_avail_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(available_o) |-> (state_o == 3'd1));

endmodule

bind tx_frame_slot tx_frame_slot_chk #(.RETRY_W(RETRY_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_cmd_i      (sw_cmd_i),
    .hw_cmd_i      (hw_cmd_i),
    .retry_limit_i (retry_limit_i),
    .state_o       (state_o),
    .retry_cnt_o   (retry_cnt_o),
    .available_o   (available_o)
);

// File: tb/sim_tx_frame_slot.sv
`timescale 1ns/1ps
module sim_tx_frame_slot;

    localparam int WORDS = 8;
    localparam int DW    = 16;
    localparam int RW    = 3;
    localparam int AW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    sw_cmd = '0;
    logic [2:0]    hw_cmd = '0;
    logic [RW-1:0] lim = '0;
    logic          we = 1'b0;
    logic [AW-1:0] waddr = '0;
    logic [DW-1:0] wdata = '0;
    logic [AW-1:0] raddr = '0;
    logic [DW-1:0] rdata;
    logic [2:0]    st;
    logic [RW-1:0] rcnt;
    logic          avail;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_st = 0;
    int m_rt = 0;
    logic [DW-1:0] m_mem [WORDS];

    always #4 clk = ~clk;

    tx_frame_slot #(.WORDS(WORDS), .DW(DW), .RETRY_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_cmd_i(sw_cmd), .hw_cmd_i(hw_cmd),
        .retry_limit_i(lim), .sw_we_i(we), .sw_addr_i(waddr), .sw_wdata_i(wdata),
        .hw_rd_addr_i(raddr), .hw_rd_data_o(rdata), .state_o(st),
        .retry_cnt_o(rcnt), .available_o(avail)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit locked_st(int s);
        return (s == 1) || (s == 2) || (s == 3);
    endfunction

    // Next state from the requirements; returns the requirement tag
    function automatic string model(int sw, int hw, int limit);
        string tag = "R3";
        case (m_st)
            0: if (sw == 1) begin m_st = 1; m_rt = 0; tag = "R2"; end
            1: begin
                if (sw == 3) begin m_st = 5; tag = (hw == 1) ? "R10" : "R8"; end
                else if (hw == 1) begin m_st = 2; tag = "R5"; end
            end
            2: begin
                tag = "R5";
                if (hw == 2) begin m_st = 4; if (sw == 3) tag = "R10"; end
                else if (hw == 4) begin m_st = 6; if (sw == 3) tag = "R10"; end
                else if (hw == 3) begin
                    if (sw == 3) begin m_st = 5; tag = "R10"; end
                    else if (m_rt == limit) begin m_st = 6; tag = "R7"; end
                    else begin m_st = 1; m_rt++; tag = "R6"; end
                end else if (sw == 3) begin m_st = 3; tag = "R8"; end
            end
            3: begin
                tag = "R9";
                if (hw == 2) m_st = 4;
                else if (hw == 4) m_st = 6;
                else if (hw == 3) m_st = 5;
            end
            default: begin
                if (sw == 1) begin m_st = 1; m_rt = 0; tag = "R2"; end
                else if (sw == 2) begin m_st = 0; tag = "R4"; end
            end
        endcase
        return tag;
    endfunction

    // Drive one cycle at a falling edge, check at the next falling edge
    task automatic step(input int sw, input int hw, input bit w, input int wa,
                        input int wd, input int ra, input string rtag);
        string tag;
        logic [DW-1:0] exp_rd;
        sw_cmd = 2'(sw); hw_cmd = 3'(hw); we = w;
        waddr = AW'(wa); wdata = DW'(wd); raddr = AW'(ra);
        exp_rd = m_mem[ra];
        if (w && !locked_st(m_st)) m_mem[wa] = DW'(wd);
        tag = model(sw, hw, int'(lim));
        @(posedge clk);
        @(negedge clk);
        chk(tag, int'(st), m_st);
        chk(tag, int'(rcnt), m_rt);
        chk("R11", int'(avail), (m_st == 1) ? 1 : 0);
        chk(rtag, int'(rdata), int'(exp_rd));
        sw_cmd = '0; hw_cmd = '0; we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1CE5));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset values
        chk("R1", int'(st), 0);
        chk("R1", int'(rcnt), 0);
        chk("R1", int'(avail), 0);
        chk("R1", int'(rdata), 0);

        // R12: fill every word while Empty
        for (int i = 0; i < WORDS; i++) begin
            m_mem[i] = '0;
            step(0, 0, 1'b1, i, 16'hA000 + i, 0, "R12");
        end
        step(0, 0, 1'b1, 5, 16'h5A5A, 5, "R12");   // same-cycle read sees old word
        step(0, 0, 1'b0, 0, 0, 5, "R12");
        step(2, 0, 1'b0, 0, 0, 1, "R12");          // R3: set-empty in Empty ignored
        lim = 3'd2;
        step(1, 0, 1'b0, 0, 0, 2, "R12");          // R2: to Ready
        step(0, 0, 1'b1, 3, 16'hDEAD, 3, "R13");   // R13: write blocked in Ready
        step(0, 0, 1'b0, 0, 0, 3, "R13");
        step(2, 0, 1'b0, 0, 0, 0, "R12");          // R3: set-empty in Ready
        step(0, 1, 1'b0, 0, 0, 0, "R12");          // R5: lock
        step(0, 0, 1'b1, 4, 16'hBEEF, 4, "R13");   // R13: blocked in Sending
        step(0, 0, 1'b0, 0, 0, 4, "R13");
        step(3, 0, 1'b0, 0, 0, 0, "R12");          // R8: abort while sending
        step(0, 0, 1'b1, 6, 16'h1111, 6, "R13");   // R13: blocked in AbortPending
        step(0, 0, 1'b0, 0, 0, 6, "R13");
        step(0, 3, 1'b0, 0, 0, 0, "R12");          // R9: one attempt then Aborted
        step(1, 0, 1'b0, 0, 0, 0, "R12");
        step(0, 1, 1'b0, 0, 0, 0, "R12");
        step(0, 3, 1'b0, 0, 0, 0, "R12");          // R6: retry 1
        step(0, 1, 1'b0, 0, 0, 0, "R12");
        step(0, 3, 1'b0, 0, 0, 0, "R12");          // R6: retry 2
        step(0, 1, 1'b0, 0, 0, 0, "R12");
        step(0, 3, 1'b0, 0, 0, 0, "R12");          // R7: limit reached, Failed
        step(2, 0, 1'b0, 0, 0, 0, "R12");          // R4: back to Empty
        step(1, 0, 1'b0, 0, 0, 0, "R12");
        step(3, 1, 1'b0, 0, 0, 0, "R12");          // R10: abort beats lock
        step(1, 0, 1'b0, 0, 0, 0, "R12");
        step(0, 1, 1'b0, 0, 0, 0, "R12");
        step(3, 2, 1'b0, 0, 0, 0, "R12");          // R10: abort with unlock-ok
        lim = 3'd0;
        step(1, 0, 1'b0, 0, 0, 0, "R12");
        step(0, 1, 1'b0, 0, 0, 0, "R12");
        step(0, 3, 1'b0, 0, 0, 0, "R12");          // R7: limit 0 fails at once
        lim = 3'd2;

        // Random phase: legal hardware codes for the modelled state
        for (int n = 0; n < 4000; n++) begin
            int sw, hw, r;
            sw = int'($urandom_range(0, 3));
            if ($urandom_range(0, 2) == 0) sw = 0;
            hw = 0;
            r = int'($urandom_range(0, 3));
            if (m_st == 1 && r < 2) hw = 1;
            else if (m_st == 2 || m_st == 3) hw = (r == 0) ? 0 : r + 1;
            step(sw, hw, 1'($urandom_range(0, 1)), int'($urandom_range(0, WORDS-1)),
                 int'($urandom_range(0, 16'hFFFF)), int'($urandom_range(0, WORDS-1)), "R12");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule